// File: doc/BRIEF.md
# Taken-Branch Target Cache with Instruction Folding

This block is a small fully associative table that the fetch stage searches with its current program counter. The search happens in the same cycle that the address goes to instruction memory. When a stored branch address equals the fetch address, the block returns that branch's recorded destination as the next fetch address and signals a taken prediction. Fetch can therefore redirect without losing a cycle. When nothing matches, the next address is the sequential one.

The table holds only branches expected to be taken. The execute stage owns a single write port and reports each resolved branch: its address, whether it was taken, its real destination, whether it is unconditional, and the instruction word found at the destination. A taken outcome refreshes an existing entry or allocates a new one. A not-taken outcome removes any entry for that address and never creates one. Entries for unconditional branches also keep the destination instruction word. A hit on such an entry hands that word to fetch so that it can replace the branch, which makes the branch cost zero cycles.

Top module: `btb_fold`

## Requirements
- R1: After a synchronous active-low reset, every entry is empty, so no fetch address produces a hit until an update installs one.
- R2: A lookup whose fetch address equals a stored branch address sets `hit` and `pred_taken` to 1 and drives `pred_pc` with the stored destination in the same cycle, with no register on the path.
- R3: A lookup that matches no valid entry gives `hit` = 0, `pred_taken` = 0 and `pred_pc` = `fetch_pc` + `INSN_BYTES` (default 4).
- R4: An update with `upd_taken` = 0 never allocates an entry. If an entry for `upd_pc` exists, that entry is invalidated.
- R5: A taken update whose address is absent is written into the lowest-numbered empty entry, when one exists.
- R6: A taken update whose address is absent while all `ENTRIES` entries are valid replaces the entry selected by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each such replacement only.
- R7: A hit on an entry installed with `upd_uncond` = 1 sets `fold_valid` = 1 and drives `fold_insn` with the stored destination instruction word.
- R8: A hit on an entry installed with `upd_uncond` = 0 gives `fold_valid` = 0. A miss also gives `fold_valid` = 0.
- R9: When an update and a lookup address the same branch in the same cycle, the lookup sees the contents from before the update. The update becomes visible from the next cycle on.
- R10: A taken update for an address already present overwrites that entry's destination, unconditional flag and instruction word in place, without creating a second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | PC_W | Address presented by fetch this cycle |
| hit | output | 1 | A valid entry matches `fetch_pc` |
| pred_taken | output | 1 | Taken prediction for the fetched address |
| pred_pc | output | PC_W | Predicted next fetch address |
| fold_valid | output | 1 | `fold_insn` may replace the fetched branch |
| fold_insn | output | INSN_W | Destination instruction word of an unconditional hit, zero otherwise |
| upd_valid | input | 1 | Execute stage reports a resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | PC_W | Resolved destination address |
| upd_uncond | input | 1 | The branch is unconditional |
| upd_insn | input | INSN_W | Instruction word at the destination |

## Verification
A corrupted valid bit or tag shows up on the first lookup of the affected address. It appears either as a stale hit that redirects fetch or as a lost hit that falls back to the sequential address. A wrong round-robin pointer stays hidden while free entries remain. It becomes visible only once the table is full and a replacement evicts the wrong branch, and then only when the evicted address is fetched again. For that reason the bench fills the table, overflows it several times and looks up every address it has ever installed, in every cycle. A wrong unconditional flag or instruction word shows immediately on the `fold_valid` and `fold_insn` outputs of the next hit on that entry.

// File: rtl/btb_fold_pkg.sv
// Package btb_fold_pkg
// Shared encodings for the taken-branch target cache. It assumes nothing
// beyond the standard integer types.
package btb_fold_pkg;

    // Classification of one execute-stage report against the table contents
    typedef enum logic [1:0] {
        UPD_IDLE    = 2'd0,  // no report, or not-taken for an absent address
        UPD_REFRESH = 2'd1,  // taken, address present: rewrite in place
        UPD_INSTALL = 2'd2,  // taken, address absent: allocate an entry
        UPD_DROP    = 2'd3   // not taken, address present: invalidate
    } upd_kind_e;

    // Next value of a wrapping pointer over n slots
    function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/btb_cam.sv
// Module btb_cam
// Compares one key against every stored tag in parallel and reports whether
// a valid tag matches and at which index. It assumes the table never holds
// two valid copies of the same tag; if it did, the highest index would win.
module btb_cam #(
    parameter int N    = 8,
    parameter int PC_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [PC_W-1:0]  key,
    input  logic [N-1:0]     valid,
    input  logic [PC_W-1:0]  tags [N],
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] match;

    // One comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    // Reduce the match vector to a hit flag and an index
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/btb_victim.sv
// Module btb_victim
// Chooses the slot for a new entry: the lowest empty slot when one exists,
// otherwise the slot under a round-robin pointer. The pointer moves only when
// a full table is actually overwritten. It assumes `alloc` is asserted only in
// cycles that write the chosen slot.
module btb_victim
    import btb_fold_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             alloc,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;

    // Priority search for the lowest-numbered empty slot
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        slot = has_free ? free_idx : rr_q;
    end

    // Round-robin pointer, stepped on each replacement of a valid entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (alloc && !has_free) begin
            rr_q <= IDX_W'(wrap_inc(int'(rr_q), N));
        end
    end

endmodule

// File: rtl/btb_store.sv
// Module btb_store
// Register array of entries: valid bit, branch address, destination,
// unconditional flag and destination instruction word. One write and one
// invalidate per cycle; it assumes the two never target the same slot.
module btb_store #(
    parameter int N      = 8,
    parameter int PC_W   = 32,
    parameter int INSN_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [PC_W-1:0]   wr_target,
    input  logic              wr_uncond,
    input  logic [INSN_W-1:0] wr_insn,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [N-1:0]      valid_q,
    output logic [PC_W-1:0]   pc_q     [N],
    output logic [PC_W-1:0]   target_q [N],
    output logic [N-1:0]      uncond_q,
    output logic [INSN_W-1:0] insn_q   [N]
);

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic sel_wr;
        logic sel_clr;

        assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
        assign sel_clr = clr_en && (clr_idx == IDX_W'(g));

        // Entry state: cleared on reset, written on install or refresh, dropped on not-taken
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g]  <= 1'b0;
                pc_q[g]     <= '0;
                target_q[g] <= '0;
                uncond_q[g] <= 1'b0;
                insn_q[g]   <= '0;
            end else if (sel_wr) begin
                valid_q[g]  <= 1'b1;
                pc_q[g]     <= wr_pc;
                target_q[g] <= wr_target;
                uncond_q[g] <= wr_uncond;
                insn_q[g]   <= wr_insn;
            end else if (sel_clr) begin
                valid_q[g]  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/btb_fold.sv
// Module btb_fold
// Taken-branch target cache searched by the fetch address in the same cycle.
// On a hit it supplies the stored destination and a taken flag, and for
// unconditional entries the destination instruction word to fold in place of
// the branch. Execute-stage reports write at the clock edge, so a lookup in
// the same cycle sees the old contents. It assumes one report per cycle.
module btb_fold
    import btb_fold_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int INSN_W     = 32,
    parameter int ENTRIES    = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              hit,
    output logic              pred_taken,
    output logic [PC_W-1:0]   pred_pc,
    output logic              fold_valid,
    output logic [INSN_W-1:0] fold_insn,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [PC_W-1:0]   upd_target,
    input  logic              upd_uncond,
    input  logic [INSN_W-1:0] upd_insn
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [PC_W-1:0]    pc_q     [ENTRIES];
    logic [PC_W-1:0]    target_q [ENTRIES];
    logic [ENTRIES-1:0] uncond_q;
    logic [INSN_W-1:0]  insn_q   [ENTRIES];

    logic               f_hit;
    logic [IDX_W-1:0]   f_idx;
    logic               u_hit;
    logic [IDX_W-1:0]   u_idx;
    logic [IDX_W-1:0]   victim;
    upd_kind_e          kind;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;

    // Fetch-side search
    btb_cam #(.N(ENTRIES), .PC_W(PC_W)) u_fetch_cam (
        .key   (fetch_pc),
        .valid (valid_q),
        .tags  (pc_q),
        .hit   (f_hit),
        .idx   (f_idx)
    );

    // Execute-side search, to find an existing entry for the report
    btb_cam #(.N(ENTRIES), .PC_W(PC_W)) u_upd_cam (
        .key   (upd_pc),
        .valid (valid_q),
        .tags  (pc_q),
        .hit   (u_hit),
        .idx   (u_idx)
    );

    // Classify the execute-stage report
    always_comb begin
        kind = UPD_IDLE;
        if (upd_valid) begin
            if (upd_taken) kind = u_hit ? UPD_REFRESH : UPD_INSTALL;
            else if (u_hit) kind = UPD_DROP;
        end
        wr_en  = (kind == UPD_REFRESH) || (kind == UPD_INSTALL);
        wr_idx = (kind == UPD_REFRESH) ? u_idx : victim;
    end

    btb_victim #(.N(ENTRIES)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid_q),
        .alloc (kind == UPD_INSTALL),
        .slot  (victim)
    );

    btb_store #(.N(ENTRIES), .PC_W(PC_W), .INSN_W(INSN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_pc     (upd_pc),
        .wr_target (upd_target),
        .wr_uncond (upd_uncond),
        .wr_insn   (upd_insn),
        .clr_en    (kind == UPD_DROP),
        .clr_idx   (u_idx),
        .valid_q   (valid_q),
        .pc_q      (pc_q),
        .target_q  (target_q),
        .uncond_q  (uncond_q),
        .insn_q    (insn_q)
    );

    // Prediction outputs: destination on a hit, sequential address otherwise
    always_comb begin
        hit        = f_hit;
        pred_taken = f_hit;
        pred_pc    = f_hit ? target_q[f_idx] : fetch_pc + PC_W'(INSN_BYTES);
        fold_valid = f_hit && uncond_q[f_idx];
        fold_insn  = fold_valid ? insn_q[f_idx] : '0;
    end

endmodule

// File: rtl/btb_fold_chk.sv
// Module btb_fold_chk
// Port-level properties of btb_fold, attached by bind. It assumes the bench
// holds reset low for at least one clock at start.
module btb_fold_chk #(
    parameter int PC_W   = 32,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              hit,
    input logic              pred_taken,
    input logic              fold_valid,
    input logic [PC_W-1:0]   pred_pc,
    input logic [INSN_W-1:0] fold_insn,
    input logic              upd_valid,
    input logic [PC_W-1:0]   upd_pc,
    input logic              upd_taken,
    input logic [PC_W-1:0]   upd_target,
    input logic              upd_uncond,
    input logic [INSN_W-1:0] upd_insn
);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit); // R1

    AST_NOT_TAKEN_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=> (fetch_pc != $past(upd_pc)) || !hit); // R4

    AST_TAKEN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            (fetch_pc != $past(upd_pc)) || (hit && pred_taken && pred_pc == $past(upd_target))); // R10

    AST_UNCOND_FOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_uncond) |=>
            (fetch_pc != $past(upd_pc)) || (fold_valid && fold_insn == $past(upd_insn))); // R7

    AST_COND_NO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && !upd_uncond) |=>
            (fetch_pc != $past(upd_pc)) || !fold_valid); // R8

    AST_FOLD_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fold_valid |-> hit); // R8

endmodule

bind btb_fold btb_fold_chk #(.PC_W(PC_W), .INSN_W(INSN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .hit        (hit),
    .pred_taken (pred_taken),
    .fold_valid (fold_valid),
    .pred_pc    (pred_pc),
    .fold_insn  (fold_insn),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_target (upd_target),
    .upd_uncond (upd_uncond),
    .upd_insn   (upd_insn)
);

// File: tb/btb_fold_tb.sv
module btb_fold_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        hit, pred_taken, fold_valid;
    logic [31:0] pred_pc, fold_insn;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_uncond = 1'b0;
    logic [31:0] upd_insn = '0;

    int checks = 0;
    int errors = 0;

    // Behavioural model: slot contents plus replacement pointer
    bit          m_v   [N];
    logic [31:0] m_pc  [N];
    logic [31:0] m_tg  [N];
    bit          m_u   [N];
    logic [31:0] m_in  [N];
    int          m_rr = 0;
    logic [31:0] seen [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_fold u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .hit(hit), .pred_taken(pred_taken), .pred_pc(pred_pc),
        .fold_valid(fold_valid), .fold_insn(fold_insn),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_uncond(upd_uncond), .upd_insn(upd_insn)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [31:0] pc);
        for (int i = 0; i < N; i++) if (m_v[i] && m_pc[i] == pc) return i;
        return -1;
    endfunction

    task automatic m_update(logic [31:0] pc, bit tk, logic [31:0] tg, bit u, logic [31:0] ins);
        int j;
        j = m_find(pc);
        if (tk) begin
            if (j < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) j = i;
                if (j < 0) begin
                    j = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                seen.push_back(pc);
            end
            m_v[j] = 1; m_pc[j] = pc; m_tg[j] = tg; m_u[j] = u; m_in[j] = ins;
        end else if (j >= 0) begin
            m_v[j] = 0;
        end
    endtask

    // One clock: drive, compare outputs against the model, then advance the model
    task automatic cyc(string tag, logic [31:0] fpc, bit uv, logic [31:0] upc,
                       bit ut, logic [31:0] utg, bit uu, logic [31:0] uin);
        int j;
        string t;
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        upd_target = utg; upd_uncond = uu; upd_insn = uin;
        #(CLK_PERIOD/4);
        j = m_find(fpc);
        if (j >= 0) begin
            t = {tag, "/R2"};
            chk(t, "hit", 32'(hit), 32'd1);
            chk(t, "pred_taken", 32'(pred_taken), 32'd1);
            chk(t, "pred_pc", pred_pc, m_tg[j]);
            if (m_u[j]) begin
                chk({tag, "/R7"}, "fold_valid", 32'(fold_valid), 32'd1);
                chk({tag, "/R7"}, "fold_insn", fold_insn, m_in[j]);
            end else begin
                chk({tag, "/R8"}, "fold_valid", 32'(fold_valid), 32'd0);
            end
        end else begin
            t = {tag, "/R3"};
            chk(t, "hit", 32'(hit), 32'd0);
            chk(t, "pred_taken", 32'(pred_taken), 32'd0);
            chk(t, "pred_pc", pred_pc, fpc + 32'd4);
            chk({tag, "/R8"}, "fold_valid", 32'(fold_valid), 32'd0);
        end
        @(posedge clk);
        if (rst_n && uv) m_update(upc, ut, utg, uu, uin);
        @(negedge clk);
    endtask

    task automatic look(string tag, logic [31:0] fpc);
        cyc(tag, fpc, 0, '0, 0, '0, 0, '0);
    endtask

    task automatic upd(string tag, logic [31:0] pc, bit tk, logic [31:0] tg, bit u, logic [31:0] ins);
        cyc(tag, 32'hFFFF_0000, 1, pc, tk, tg, u, ins);
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < seen.size(); i++) look(tag, seen[i]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_pc[i] = '0; m_tg[i] = '0; m_u[i] = 0; m_in[i] = '0;
        end
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        look("R1", 32'h0000_0100);
        look("R1", 32'h0000_0000);
        // R9: same-cycle update and lookup see old contents, then the new entry
        cyc("R9", 32'h0000_0100, 1, 32'h0000_0100, 1, 32'h0000_0800, 0, 32'h1111_1111);
        look("R9", 32'h0000_0100);
        // R7: unconditional entry folds its instruction
        upd("R7", 32'h0000_0200, 1, 32'h0000_0900, 1, 32'hDEAD_BEEF);
        look("R7", 32'h0000_0200);
        // R10: refresh in place with a new destination
        upd("R10", 32'h0000_0100, 1, 32'h0000_0A00, 0, 32'h0);
        look("R10", 32'h0000_0100);
        upd("R10", 32'h0000_0200, 1, 32'h0000_0B00, 0, 32'h0);
        look("R10", 32'h0000_0200);
        // R4: not-taken invalidates, and never allocates
        upd("R4", 32'h0000_0100, 0, 32'h0000_0C00, 0, 32'h0);
        look("R4", 32'h0000_0100);
        upd("R4", 32'h0000_0300, 0, 32'h0000_0D00, 1, 32'h5);
        look("R4", 32'h0000_0300);
        // R5: fill free slots lowest-first
        for (int k = 0; k < 7; k++) begin
            upd("R5", 32'h0000_1000 + 32'(k) * 16, 1, 32'h0000_4000 + 32'(k) * 8,
                k[0], 32'hA000_0000 + 32'(k));
            sweep("R5");
        end
        // R6: full table, round-robin replacement
        for (int k = 0; k < 12; k++) begin
            upd("R6", 32'h0000_2000 + 32'(k) * 16, 1, 32'h0000_5000 + 32'(k) * 8,
                k[1], 32'hB000_0000 + 32'(k));
            sweep("R6");
        end
        // R4 then R5: free a slot in a full table and refill it
        upd("R4", 32'h0000_20B0, 0, '0, 0, '0);
        upd("R5", 32'h0000_3000, 1, 32'h0000_6000, 1, 32'hC0DE_0001);
        upd("R6", 32'h0000_3010, 1, 32'h0000_6010, 0, 32'h0);
        sweep("R6");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule